// File: doc/BRIEF.md
# Tagged Geometric-History Branch Direction Predictor

This block predicts whether a conditional branch is taken. It has one tagless base table of 2-bit counters, indexed by the PC alone. It also has a set of tagged tables. Each tagged table is indexed by a hash of the PC and a slice of global branch history, and the slice lengths double from one table to the next. A fetch PC presented on the lookup port yields a direction, the number of the providing component and the alternate direction, all in the same cycle. Among the tagged tables that hit, the one with the longest history wins. If no tagged table hits, the base table decides.

Once the branch resolves, the pipeline returns the PC, the real outcome, and the provider number and alternate direction it captured at lookup. The block then trains the provider counter and maintains the useful bits. After a misprediction it claims an entry in a longer table. It also shifts the outcome into the global history.

Top module: `geo_hist_predictor`

## Requirements
- R1: After reset, every base counter is 1 (weak not-taken), every tagged counter is -1, every useful bit is 0, every tag is 0 and the history is all zeros.
- R2: The base table is indexed by PC bits [9:2]. It predicts taken when its 2-bit counter is 2 or more.
- R3: Bit 0 of the global history is the newest outcome. Table k (k = 1, 2, 3) uses history bits [Lk-1:0], with L = 5, 10, 20. To fold history bits to width w, history bit j is XORed into folded bit j mod w. Index = PC[7:2] XOR fold(6). Tag = PC[9:2] XOR fold(8) XOR (fold(7) shifted left by one). A table hits when the stored tag equals the tag just computed.
- R4: The provider code is 0 for the base table and k for tagged table k. The highest hitting k provides. A tagged counter predicts taken when it is 0 or more. The alternate direction is the prediction of the next lower hitting table, or of the base table.
- R5: The direction, provider and alternate outputs depend only on the lookup PC and the current state, within the same cycle.
- R6: An update trains only the provider counter, one step toward the outcome, saturating at 0..3 for the base table and at -4..3 for a tagged table.
- R7: If a tagged provider's prediction differs from the alternate, its useful bit becomes 1 when the provider was right and 0 when it was wrong.
- R8: On a misprediction, the lowest-numbered table above the provider whose useful bit is 0 is allocated. It gets the new tag, a counter of 0 when the branch was taken or -1 when it was not, and a useful bit of 0.
- R9: On a misprediction where every table above the provider has its useful bit set, all of those useful bits are cleared and nothing is allocated.
- R10: Each update shifts its outcome into history bit 0. Cycles without an update leave all state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pred_pc_i | input | 32 | Fetch PC to look up |
| pred_taken_o | output | 1 | Predicted direction |
| pred_prov_o | output | 2 | Providing component (0 = base) |
| pred_alt_o | output | 1 | Alternate direction |
| upd_valid_i | input | 1 | Resolved branch update strobe |
| upd_pc_i | input | 32 | PC of the resolved branch |
| upd_taken_i | input | 1 | Actual outcome |
| upd_prov_i | input | 2 | Provider captured at lookup |
| upd_alt_i | input | 1 | Alternate direction captured at lookup |

## Verification
The bench uses the default parameters: three tagged tables of 64 entries, 8-bit tags, history lengths of 5, 10 and 20, and 256 base entries. With tables this small, a stream of a few thousand branches over sixteen PCs aliases heavily. That drives allocations into every level, sets useful bits on all candidate tables so that they must be cleared, and pushes counters to saturation at both ends. A four-iteration loop pattern shows a longer table taking over from the base table as the provider. Lookups made with no update show that the state is held.

// File: rtl/geo_pred_pkg.sv
package geo_pred_pkg;
  // XOR-fold the low len bits of h down to w bits (w <= 16)
  function automatic logic [15:0] fold_hist(input logic [63:0] h, input int len, input int w);
    logic [15:0] r;
    r = '0;
    for (int i = 0; i < 64; i++)
      if (i < len) r[i % w] = r[i % w] ^ h[i];
    return r;
  endfunction
endpackage

// File: rtl/geo_base_tbl.sv
module geo_base_tbl #(
  parameter int PC_W   = 32,
  parameter int PC_LSB = 2,
  parameter int IDX_W  = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] rd_pc_i,
  output logic            rd_taken_o,
  input  logic [PC_W-1:0] up_pc_i,
  output logic [1:0]      up_ctr_o,
  input  logic            train_en_i,
  input  logic            train_dir_i
);
  localparam int DEPTH = 1 << IDX_W;

  logic [1:0]       cnt_q [DEPTH];
  logic [IDX_W-1:0] rd_idx, up_idx;

  assign rd_idx     = rd_pc_i[PC_LSB +: IDX_W];
  assign up_idx     = up_pc_i[PC_LSB +: IDX_W];
  assign rd_taken_o = cnt_q[rd_idx][1];
  assign up_ctr_o   = cnt_q[up_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) cnt_q[i] <= 2'd1;
    end else if (train_en_i) begin
      if (train_dir_i && cnt_q[up_idx] != 2'd3)      cnt_q[up_idx] <= cnt_q[up_idx] + 2'd1;
      else if (!train_dir_i && cnt_q[up_idx] != 2'd0) cnt_q[up_idx] <= cnt_q[up_idx] - 2'd1;
    end
  end

  // R6
  base_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (train_en_i && train_dir_i) |=> cnt_q[$past(up_idx)] != 2'd0);
  // R6
  base_dn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (train_en_i && !train_dir_i) |=> cnt_q[$past(up_idx)] != 2'd3);
endmodule

// File: rtl/geo_tag_tbl.sv
module geo_tag_tbl
  import geo_pred_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int PC_LSB   = 2,
  parameter int IDX_W    = 6,
  parameter int TAG_W    = 8,
  parameter int CTR_W    = 3,
  parameter int HIST_W   = 20,
  parameter int HIST_LEN = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HIST_W-1:0] hist_i,
  input  logic [PC_W-1:0]   rd_pc_i,
  output logic              rd_hit_o,
  output logic [CTR_W-1:0]  rd_ctr_o,
  input  logic [PC_W-1:0]   up_pc_i,
  output logic [CTR_W-1:0]  up_ctr_o,
  output logic              up_useful_o,
  input  logic              train_en_i,
  input  logic              train_dir_i,
  input  logic              u_wr_i,
  input  logic              u_val_i,
  input  logic              alloc_en_i,
  input  logic              alloc_dir_i
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CTR_W-1:0] CTR_MAX = {1'b0, {(CTR_W-1){1'b1}}};
  localparam logic [CTR_W-1:0] CTR_MIN = {1'b1, {(CTR_W-1){1'b0}}};

  logic [CTR_W-1:0] ctr_q [DEPTH];
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic             u_q   [DEPTH];
  logic [63:0]      hist_ext;

  assign hist_ext = 64'(hist_i);

  function automatic logic [IDX_W-1:0] idx_of(input logic [PC_W-1:0] pc, input logic [63:0] h);
    logic [15:0] f;
    f = fold_hist(h, HIST_LEN, IDX_W);
    return pc[PC_LSB +: IDX_W] ^ f[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [PC_W-1:0] pc, input logic [63:0] h);
    logic [15:0] f1, f2;
    f1 = fold_hist(h, HIST_LEN, TAG_W);
    f2 = fold_hist(h, HIST_LEN, TAG_W - 1);
    return pc[PC_LSB +: TAG_W] ^ f1[TAG_W-1:0] ^ {f2[TAG_W-2:0], 1'b0};
  endfunction

  logic [IDX_W-1:0] rd_idx, up_idx;
  logic [TAG_W-1:0] rd_tag, up_tag;

  assign rd_idx = idx_of(rd_pc_i, hist_ext);
  assign rd_tag = tag_of(rd_pc_i, hist_ext);
  assign up_idx = idx_of(up_pc_i, hist_ext);
  assign up_tag = tag_of(up_pc_i, hist_ext);

  assign rd_hit_o    = (tag_q[rd_idx] == rd_tag);
  assign rd_ctr_o    = ctr_q[rd_idx];
  assign up_ctr_o    = ctr_q[up_idx];
  assign up_useful_o = u_q[up_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        ctr_q[i] <= '1;
        tag_q[i] <= '0;
        u_q[i]   <= 1'b0;
      end
    end else if (alloc_en_i) begin
      tag_q[up_idx] <= up_tag;
      ctr_q[up_idx] <= alloc_dir_i ? '0 : '1;
      u_q[up_idx]   <= 1'b0;
    end else begin
      if (train_en_i) begin
        if (train_dir_i && ctr_q[up_idx] != CTR_MAX)       ctr_q[up_idx] <= ctr_q[up_idx] + 1'b1;
        else if (!train_dir_i && ctr_q[up_idx] != CTR_MIN) ctr_q[up_idx] <= ctr_q[up_idx] - 1'b1;
      end
      if (u_wr_i) u_q[up_idx] <= u_val_i;
    end
  end

  // R8
  alloc_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(alloc_en_i && (train_en_i || u_wr_i)));
  // R8
  alloc_fresh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_en_i |=> (u_q[$past(up_idx)] == 1'b0));
  // R6
  train_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (train_en_i && train_dir_i && !alloc_en_i) |=> ctr_q[$past(up_idx)] != CTR_MIN);
endmodule

// File: rtl/geo_hist_predictor.sv
module geo_hist_predictor #(
  parameter int PC_W     = 32,
  parameter int PC_LSB   = 2,
  parameter int BASE_IW  = 8,
  parameter int NUM_TBL  = 3,
  parameter int TBL_IW   = 6,
  parameter int TAG_W    = 8,
  parameter int CTR_W    = 3,
  parameter int MIN_HIST = 5,
  localparam int PROV_W  = $clog2(NUM_TBL + 1),
  localparam int HIST_W  = MIN_HIST << (NUM_TBL - 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PC_W-1:0]   pred_pc_i,
  output logic              pred_taken_o,
  output logic [PROV_W-1:0] pred_prov_o,
  output logic              pred_alt_o,
  input  logic              upd_valid_i,
  input  logic [PC_W-1:0]   upd_pc_i,
  input  logic              upd_taken_i,
  input  logic [PROV_W-1:0] upd_prov_i,
  input  logic              upd_alt_i
);
  logic [HIST_W-1:0] ghist_q;

  logic       b_rd_taken, b_train;
  logic [1:0] b_up_ctr;

  logic [NUM_TBL-1:0] t_hit, t_up_u, t_train, t_uwr, t_uval, t_alloc, cand, sel;
  logic [CTR_W-1:0]   t_rd_ctr [NUM_TBL];
  logic [CTR_W-1:0]   t_up_ctr [NUM_TBL];

  geo_base_tbl #(.PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_W(BASE_IW)) u_base (
    .clk_i, .rst_ni,
    .rd_pc_i    (pred_pc_i),
    .rd_taken_o (b_rd_taken),
    .up_pc_i    (upd_pc_i),
    .up_ctr_o   (b_up_ctr),
    .train_en_i (b_train),
    .train_dir_i(upd_taken_i)
  );

  for (genvar g = 0; g < NUM_TBL; g++) begin : g_tbl
    geo_tag_tbl #(
      .PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_W(TBL_IW), .TAG_W(TAG_W),
      .CTR_W(CTR_W), .HIST_W(HIST_W), .HIST_LEN(MIN_HIST << g)
    ) u_tbl (
      .clk_i, .rst_ni,
      .hist_i      (ghist_q),
      .rd_pc_i     (pred_pc_i),
      .rd_hit_o    (t_hit[g]),
      .rd_ctr_o    (t_rd_ctr[g]),
      .up_pc_i     (upd_pc_i),
      .up_ctr_o    (t_up_ctr[g]),
      .up_useful_o (t_up_u[g]),
      .train_en_i  (t_train[g]),
      .train_dir_i (upd_taken_i),
      .u_wr_i      (t_uwr[g]),
      .u_val_i     (t_uval[g]),
      .alloc_en_i  (t_alloc[g]),
      .alloc_dir_i (upd_taken_i)
    );
  end

  // lookup: walk short to long, the last hit wins
  always_comb begin
    pred_taken_o = b_rd_taken;
    pred_alt_o   = b_rd_taken;
    pred_prov_o  = '0;
    for (int k = 0; k < NUM_TBL; k++) begin
      if (t_hit[k]) begin
        pred_alt_o   = pred_taken_o;
        pred_taken_o = !t_rd_ctr[k][CTR_W-1];
        pred_prov_o  = PROV_W'(k + 1);
      end
    end
  end

  logic upd_pred, mispred, found;

  always_comb begin
    upd_pred = b_up_ctr[1];
    for (int k = 0; k < NUM_TBL; k++)
      if (int'(upd_prov_i) == k + 1) upd_pred = !t_up_ctr[k][CTR_W-1];
  end

  assign mispred = upd_valid_i && (upd_pred != upd_taken_i);
  assign b_train = upd_valid_i && (upd_prov_i == '0);

  always_comb begin
    found = 1'b0;
    for (int k = 0; k < NUM_TBL; k++) begin
      cand[k]    = (k + 1 > int'(upd_prov_i)) && !t_up_u[k];
      sel[k]     = cand[k] && !found;
      found      = found | cand[k];
      t_train[k] = upd_valid_i && (int'(upd_prov_i) == k + 1);
    end
    for (int k = 0; k < NUM_TBL; k++) begin
      t_alloc[k] = mispred && sel[k];
      t_uwr[k]   = (t_train[k] && (upd_pred != upd_alt_i))
                 || (mispred && !found && (k + 1 > int'(upd_prov_i)));
      t_uval[k]  = t_train[k] && (upd_pred == upd_taken_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ghist_q <= '0;
    else if (upd_valid_i) ghist_q <= {ghist_q[HIST_W-2:0], upd_taken_i};
  end

  // R10
  hist_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> ghist_q[0] == $past(upd_taken_i));
  // R10
  hist_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> $stable(ghist_q));
  // R8
  alloc_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(t_alloc));
  // R4
  prov_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(pred_prov_o) <= NUM_TBL);
  // R9
  clr_no_alloc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t_alloc != '0) |-> (t_uwr & ~t_train) == '0);
endmodule

// File: tb/tb_geo_hist_predictor.sv
module tb_geo_hist_predictor;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] pred_pc_i = '0;
  logic        pred_taken_o;
  logic [1:0]  pred_prov_o;
  logic        pred_alt_o;
  logic        upd_valid_i = 1'b0;
  logic [31:0] upd_pc_i = '0;
  logic        upd_taken_i = 1'b0;
  logic [1:0]  upd_prov_i = '0;
  logic        upd_alt_i = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  geo_hist_predictor dut (.*);

  // reference state
  int bc [256];
  int tc [3][64];
  int tt [3][64];
  int tu [3][64];
  bit [19:0] gh;

  function automatic int fold(int len, int w);
    int r = 0;
    for (int j = 0; j < len; j++) if (gh[j]) r ^= (1 << (j % w));
    return r;
  endfunction

  function automatic int m_idx(int k, int pc);
    return ((pc >> 2) & 63) ^ fold(5 << k, 6);
  endfunction

  function automatic int m_tag(int k, int pc);
    return (((pc >> 2) & 255) ^ fold(5 << k, 8) ^ (fold(5 << k, 7) << 1)) & 255;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 256; i++) bc[i] = 1;
    for (int k = 0; k < 3; k++)
      for (int i = 0; i < 64; i++) begin tc[k][i] = -1; tt[k][i] = 0; tu[k][i] = 0; end
    gh = '0;
  endtask

  task automatic m_predict(input int pc, output bit p, output int prov, output bit alt);
    p = bc[(pc >> 2) & 255] >= 2; alt = p; prov = 0;
    for (int k = 0; k < 3; k++)
      if (tt[k][m_idx(k, pc)] == m_tag(k, pc)) begin
        alt = p; p = tc[k][m_idx(k, pc)] >= 0; prov = k + 1;
      end
  endtask

  task automatic m_update(input int pc, input bit tk, input int prov, input bit alt);
    int ix [3];
    bit pp;
    int fnd;
    for (int k = 0; k < 3; k++) ix[k] = m_idx(k, pc);
    if (prov == 0) begin
      pp = bc[(pc >> 2) & 255] >= 2;
      if (tk && bc[(pc >> 2) & 255] < 3) bc[(pc >> 2) & 255]++;
      if (!tk && bc[(pc >> 2) & 255] > 0) bc[(pc >> 2) & 255]--;
    end else begin
      pp = tc[prov-1][ix[prov-1]] >= 0;
      if (tk && tc[prov-1][ix[prov-1]] < 3) tc[prov-1][ix[prov-1]]++;
      if (!tk && tc[prov-1][ix[prov-1]] > -4) tc[prov-1][ix[prov-1]]--;
      if (pp != alt) tu[prov-1][ix[prov-1]] = (pp == tk) ? 1 : 0;
    end
    if (pp != tk) begin
      fnd = -1;
      for (int k = prov; k < 3; k++) if (fnd < 0 && tu[k][ix[k]] == 0) fnd = k;
      if (fnd >= 0) begin
        tt[fnd][ix[fnd]] = m_tag(fnd, pc);
        tc[fnd][ix[fnd]] = tk ? 0 : -1;
        tu[fnd][ix[fnd]] = 0;
      end else begin
        for (int k = prov; k < 3; k++) tu[k][ix[k]] = 0;
      end
    end
    gh = {gh[18:0], tk};
  endtask

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic step(input int pc, input bit tk, input bit upd, input string rq);
    bit ep, ea;
    int epv;
    @(negedge clk_i);
    upd_valid_i = 1'b0;
    pred_pc_i = pc;
    #1;
    m_predict(pc, ep, epv, ea);
    chk(rq, "taken", int'(pred_taken_o), int'(ep));
    chk(rq, "prov", int'(pred_prov_o), epv);
    chk(rq, "alt", int'(pred_alt_o), int'(ea));
    if (upd) begin
      upd_valid_i = 1'b1; upd_pc_i = pc; upd_taken_i = tk;
      upd_prov_i = 2'(epv); upd_alt_i = ea;
      @(posedge clk_i);
      m_update(pc, tk, epv, ea);
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int lf;
    m_reset();
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // R1 R2: reset state predicts not-taken
    foreach (bc[i]) if (i < 4) begin
      step(i * 68, 1'b0, 1'b0, "R1");
      chk("R1", "reset dir", int'(pred_taken_o), 0);
    end
    // R2 R6 R8: always-taken branch
    for (int i = 0; i < 20; i++) step(32'h40, 1'b1, 1'b1, "R2_R6_R8");
    // R3 R4 R7: loop pattern 1110
    for (int i = 0; i < 240; i++) step(32'h80, (i % 4) != 3, 1'b1, "R3_R4_R7");
    // R5 R10: lookups without update keep everything
    for (int i = 0; i < 16; i++) step(32'h200 + 4 * i, 1'b0, 1'b0, "R5_R10");
    // R8 R9 R6: aliasing stream
    lf = 32'h1d2c3b4a;
    for (int i = 0; i < 3000; i++) begin
      lf = lf * 1103515245 + 12345;
      step(32'h200 + (((lf >>> 8) & 15) << 2), ((lf >>> 20) & 3) != 0 || ((lf >>> 8) & 1) == 1,
           1'b1, "R8_R9");
    end
    // R10: hold after stream
    for (int i = 0; i < 16; i++) step(32'h200 + 4 * i, 1'b0, 1'b0, "R10");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule